// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block gathers every reset request of a chip into one system reset line and keeps a record of which requests have fired. Seven request lines come in: power-on, brown-out, the external master-clear pin (active low), the software reset instruction, watchdog expiry, trap conflict, and illegal opcode or uninitialized working-register access. Power-on and brown-out arrive as digital pulses from analog detectors outside the block. Watchdog, trap and decode logic are also outside the block and supply only their request lines.

The external pin is filtered, so short glitches are ignored. The merged reset is held for a fixed number of clocks after the last request goes away, and it is released on a clock edge. A sticky cause register records each source in its own bit. Software reads this register and can overwrite it, set bits in it or clear bits in it. These accesses are bookkeeping only and never start a reset.

The power-on request also acts as the block's own synchronous reset.

Top module: `reset_merge_unit`

## Requirements
- R1: In any cycle where `por_req`, `bor_req`, `swr_req`, `wdt_req`, `trap_req` or `iop_req` is high, or where the filtered pin is active, `sys_rst` is high in that same cycle.
- R2: A request that is active at a clock edge sets its cause bit, which is visible on `csr_rdata` from that edge on. The bit map is: bit 0 power-on, bit 1 brown-out, bit 2 illegal opcode or uninitialized register, bit 3 trap conflict, bit 4 watchdog, bit 6 software reset, bit 7 master-clear pin.
- R3: A power-on request at a clock edge makes `csr_rdata` equal to 8'h01 after that edge, whatever other requests are present.
- R4: A non-power-on request leaves every other cause bit unchanged, so bits pile up until software clears them. Requests that arrive in the same cycle each set their own bit.
- R5: When `csr_we` is high at a clock edge, `csr_op` selects the update: 0 replaces the register with `csr_wdata`, 1 ORs `csr_wdata` into it, 2 clears the bits that are 1 in `csr_wdata`, and 3 leaves it unchanged. No software access ever raises `sys_rst`.
- R6: Bit 5 of `csr_rdata` always reads 0, including after a write or set that has bit 5 high.
- R7: `mclr_n` counts as a request only once it has been sampled low at 4 consecutive clock edges. From then on it stays active until the pin is sampled high. A shorter low pulse has no effect on `sys_rst` or on the cause bits.
- R8: `sys_rst` stays high for 8 cycles after the last cycle in which any request was active. It goes low at a clock edge.
- R9: When a software clear and a hardware request target the same bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_req | input | 1 | Power-on request; also the block's synchronous reset |
| bor_req | input | 1 | Brown-out request |
| mclr_n | input | 1 | External master-clear pin, active low, unfiltered |
| swr_req | input | 1 | Software reset instruction request |
| wdt_req | input | 1 | Watchdog expiry request |
| trap_req | input | 1 | Trap conflict request |
| iop_req | input | 1 | Illegal opcode / uninitialized register request |
| csr_we | input | 1 | Cause register access strobe |
| csr_op | input | 2 | Access kind: 0 write, 1 set, 2 clear, 3 none |
| csr_wdata | input | 8 | Access data or bit mask |
| csr_rdata | output | 8 | Cause register contents |
| sys_rst | output | 1 | Merged system reset, active high |

## Verification
The properties assume the request lines and the pin settle away from the clock edge. They also assume a power-on pulse arrives before anything else happens, since it is the only thing that gives the cause register and the hold counter a defined value. All properties are disabled while a power-on request is high.

The bench drives inputs only at the falling edge and opens the run with a power-on pulse. It keeps software accesses meant to show "no reset" away from reset hold windows and from pin activity, so a reset seen there can only come from the access itself.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

    localparam int CAUSE_W = 8;

    // Cause bit positions; software decodes these
    localparam int IDX_POR  = 0;
    localparam int IDX_BOR  = 1;
    localparam int IDX_IOP  = 2;
    localparam int IDX_TRAP = 3;
    localparam int IDX_WDT  = 4;
    localparam int IDX_RSVD = 5;
    localparam int IDX_SWR  = 6;
    localparam int IDX_MCLR = 7;

    typedef logic [CAUSE_W-1:0] cause_vec_t;

    localparam cause_vec_t RSVD_MASK = cause_vec_t'(1) << IDX_RSVD;
    localparam cause_vec_t POR_ONLY  = cause_vec_t'(1) << IDX_POR;

    typedef enum logic [1:0] {
        CSR_WRITE = 2'd0,
        CSR_SET   = 2'd1,
        CSR_CLEAR = 2'd2,
        CSR_HOLD  = 2'd3
    } csr_op_e;

    // Packed MSB first, so the field order matches the bit positions above
    typedef struct packed {
        logic mclr;
        logic swr;
        logic rsvd;
        logic wdt;
        logic trap;
        logic iop;
        logic bor;
        logic por;
    } cause_t;

    function automatic cause_vec_t csr_apply(cause_vec_t cur, csr_op_e op, cause_vec_t d);
        cause_vec_t r;
        case (op)
            CSR_WRITE: r = d;
            CSR_SET:   r = cur | d;
            CSR_CLEAR: r = cur & ~d;
            default:   r = cur;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rstc_pin_filter.sv
module rstc_pin_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic clr,
    input  logic pin_n,
    output logic hit
);
    localparam int CW = $clog2(FILT_LEN + 1);
    localparam logic [CW-1:0] LIMIT = CW'(FILT_LEN);

    logic [CW-1:0] run_q;

    // Count consecutive low samples, saturating at the limit
    always_ff @(posedge clk) begin
        if (clr) begin
            run_q <= '0;
        end else if (pin_n) begin
            run_q <= '0;
        end else if (run_q != LIMIT) begin
            run_q <= run_q + 1'b1;
        end
    end

    assign hit = (run_q == LIMIT);
endmodule

// File: rtl/rstc_stretch.sv
module rstc_stretch #(
    parameter int HOLD = 8
) (
    input  logic clk,
    input  logic trig,
    output logic rst_out
);
    localparam int CW = $clog2(HOLD + 1);
    localparam logic [CW-1:0] LOAD = CW'(HOLD);

    logic [CW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (trig) begin
            left_q <= LOAD;
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    // Raised straight from the requests, released by the registered count
    assign rst_out = trig | (left_q != '0);
endmodule

// File: rtl/rstc_cause_reg.sv
module rstc_cause_reg
    import rstc_pkg::*;
(
    input  logic       clk,
    input  logic       por,
    input  cause_t     hits,
    input  logic       we,
    input  csr_op_e    op,
    input  cause_vec_t wdata,
    output cause_vec_t status
);
    cause_vec_t status_q;
    cause_vec_t sw_next;
    cause_vec_t hw_next;

    always_comb begin
        sw_next = we ? csr_apply(status_q, op, wdata) : status_q;
        // Hardware set is applied after the software update, so it wins
        hw_next = (sw_next | cause_vec_t'(hits)) & ~RSVD_MASK;
    end

    always_ff @(posedge clk) begin
        if (por) begin
            status_q <= POR_ONLY;
        end else begin
            status_q <= hw_next;
        end
    end

    assign status = status_q;
endmodule

// File: rtl/reset_merge_unit.sv
module reset_merge_unit
    import rstc_pkg::*;
#(
    parameter int FILT_LEN    = 4,
    parameter int STRETCH_CYC = 8
) (
    input  logic               clk,
    input  logic               por_req,
    input  logic               bor_req,
    input  logic               mclr_n,
    input  logic               swr_req,
    input  logic               wdt_req,
    input  logic               trap_req,
    input  logic               iop_req,
    input  logic               csr_we,
    input  logic [1:0]         csr_op,
    input  logic [CAUSE_W-1:0] csr_wdata,
    output logic [CAUSE_W-1:0] csr_rdata,
    output logic               sys_rst
);
    cause_t hits;
    logic   mclr_hit;
    logic   any_req;

    rstc_pin_filter #(.FILT_LEN(FILT_LEN)) u_filt (
        .clk   (clk),
        .clr   (por_req),
        .pin_n (mclr_n),
        .hit   (mclr_hit)
    );

    always_comb begin
        hits      = '0;
        hits.por  = por_req;
        hits.bor  = bor_req;
        hits.iop  = iop_req;
        hits.trap = trap_req;
        hits.wdt  = wdt_req;
        hits.swr  = swr_req;
        hits.mclr = mclr_hit;
    end

    assign any_req = |hits;

    rstc_stretch #(.HOLD(STRETCH_CYC)) u_hold (
        .clk     (clk),
        .trig    (any_req),
        .rst_out (sys_rst)
    );

    rstc_cause_reg u_cause (
        .clk    (clk),
        .por    (por_req),
        .hits   (hits),
        .we     (csr_we),
        .op     (csr_op_e'(csr_op)),
        .wdata  (csr_wdata),
        .status (csr_rdata)
    );
endmodule

// File: rtl/reset_merge_unit_chk.sv
module reset_merge_unit_chk #(
    parameter int HOLD = 8
) (
    input logic       clk,
    input logic       por_req,
    input logic       bor_req,
    input logic       mclr_n,
    input logic       swr_req,
    input logic       wdt_req,
    input logic       trap_req,
    input logic       iop_req,
    input logic       csr_we,
    input logic [1:0] csr_op,
    input logic [7:0] csr_wdata,
    input logic [7:0] csr_rdata,
    input logic       sys_rst
);
    localparam int QW = $clog2(HOLD + 1);
    localparam logic [QW-1:0] QMAX = QW'(HOLD);

    logic          raw_any;
    logic [QW-1:0] quiet_q;

    assign raw_any = por_req | bor_req | swr_req | wdt_req | trap_req | iop_req;

    // Cycles since the last direct request, saturating at HOLD
    always_ff @(posedge clk) begin
        if (raw_any) begin
            quiet_q <= '0;
        end else if (quiet_q != QMAX) begin
            quiet_q <= quiet_q + 1'b1;
        end
    end

    // R1
    src_asserts_rst_chk: assert property (@(posedge clk) disable iff (por_req)
        (bor_req | swr_req | wdt_req | trap_req | iop_req) |-> sys_rst);

    // R2
    wdt_flag_chk: assert property (@(posedge clk) disable iff (por_req)
        wdt_req |=> csr_rdata[4]);

    // R2
    bor_flag_chk: assert property (@(posedge clk) disable iff (por_req)
        bor_req |=> csr_rdata[1]);

    // R6
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (por_req)
        !csr_rdata[5]);

    // R5
    sw_no_reset_chk: assert property (@(posedge clk) disable iff (por_req)
        (csr_we && !sys_rst && mclr_n) |=> (!sys_rst || raw_any));

    // R5
    sw_clear_chk: assert property (@(posedge clk) disable iff (por_req)
        (csr_we && csr_op == 2'd2 && !sys_rst) |=> ((csr_rdata & $past(csr_wdata)) == 8'h00));

    // R8
    hold_window_chk: assert property (@(posedge clk) disable iff (por_req)
        (quiet_q < QMAX) |-> sys_rst);
endmodule

bind reset_merge_unit reset_merge_unit_chk #(.HOLD(STRETCH_CYC)) u_chk (
    .clk       (clk),
    .por_req   (por_req),
    .bor_req   (bor_req),
    .mclr_n    (mclr_n),
    .swr_req   (swr_req),
    .wdt_req   (wdt_req),
    .trap_req  (trap_req),
    .iop_req   (iop_req),
    .csr_we    (csr_we),
    .csr_op    (csr_op),
    .csr_wdata (csr_wdata),
    .csr_rdata (csr_rdata),
    .sys_rst   (sys_rst)
);

// File: tb/sim_reset_merge_unit.sv
`timescale 1ns/1ps
module sim_reset_merge_unit;
    localparam int FILT = 4;
    localparam int HOLD = 8;

    logic       clk = 1'b0;
    logic       por_req, bor_req, mclr_n, swr_req, wdt_req, trap_req, iop_req;
    logic       csr_we;
    logic [1:0] csr_op;
    logic [7:0] csr_wdata;
    logic [7:0] csr_rdata;
    logic       sys_rst;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Reference model state
    logic [7:0] m_status;
    int         m_low;
    int         m_hold;

    always #2 clk = ~clk;

    reset_merge_unit u0 (
        .clk(clk), .por_req(por_req), .bor_req(bor_req), .mclr_n(mclr_n),
        .swr_req(swr_req), .wdt_req(wdt_req), .trap_req(trap_req), .iop_req(iop_req),
        .csr_we(csr_we), .csr_op(csr_op), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .sys_rst(sys_rst)
    );

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        logic [7:0] hv;
        logic [7:0] s;
        hv = {(m_low >= FILT) ? 1'b1 : 1'b0, swr_req, 1'b0, wdt_req, trap_req, iop_req, bor_req, por_req};
        if (por_req) begin
            m_status = 8'h01;
        end else begin
            s = m_status;
            if (csr_we) begin
                case (csr_op)
                    2'd0: s = csr_wdata;
                    2'd1: s = s | csr_wdata;
                    2'd2: s = s & ~csr_wdata;
                    default: ;
                endcase
            end
            s = s | hv;
            s[5] = 1'b0;
            m_status = s;
        end
        if (hv != 8'h00) m_hold = HOLD;
        else if (m_hold > 0) m_hold = m_hold - 1;
        if (por_req) m_low = 0;
        else if (!mclr_n) m_low = (m_low < FILT) ? m_low + 1 : FILT;
        else m_low = 0;
    endtask

    // Compare at the middle of the low phase, then advance one clock
    task automatic tick(string tag);
        logic exp_rst;
        #1;
        exp_rst = por_req | bor_req | swr_req | wdt_req | trap_req | iop_req |
                  (m_low >= FILT) | (m_hold > 0);
        check(tag, "sys_rst", int'(sys_rst), int'(exp_rst));
        check(tag, "csr_rdata", int'(csr_rdata), int'(m_status));
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic quiet();
        por_req = 0; bor_req = 0; swr_req = 0; wdt_req = 0;
        trap_req = 0; iop_req = 0; mclr_n = 1; csr_we = 0;
        csr_op = 2'd3; csr_wdata = 8'h00;
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) tick(tag);
    endtask

    task automatic sw(logic [1:0] op, logic [7:0] d, string tag);
        csr_we = 1; csr_op = op; csr_wdata = d;
        tick(tag);
        csr_we = 0; csr_op = 2'd3; csr_wdata = 8'h00;
    endtask

    initial begin
        quiet();
        por_req = 1;
        m_status = 8'h00; m_low = 0; m_hold = 0;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        // R3: reset state after power-on, with brown-out present too
        bor_req = 1;
        tick("R3");
        quiet();
        check("R3", "status after power-on", int'(csr_rdata), 8'h01);
        idle(HOLD + 3, "R8");
        check("R8", "released after hold", int'(sys_rst), 0);

        // R1/R2: each source alone
        bor_req = 1;  tick("R1"); bor_req = 0;  idle(HOLD + 2, "R2");
        iop_req = 1;  tick("R1"); iop_req = 0;  idle(HOLD + 2, "R2");
        trap_req = 1; tick("R1"); trap_req = 0; idle(HOLD + 2, "R2");
        wdt_req = 1;  tick("R1"); wdt_req = 0;  idle(HOLD + 2, "R2");
        swr_req = 1;  tick("R1"); swr_req = 0;  idle(HOLD + 2, "R4");
        check("R4", "accumulated flags", int'(csr_rdata), 8'h5F);

        // R5/R6: software ops with no reset
        sw(2'd0, 8'h00, "R5");
        check("R5", "cleared by write", int'(csr_rdata), 8'h00);
        sw(2'd1, 8'hA4, "R6");
        check("R6", "set with bit5", int'(csr_rdata), 8'h84);
        sw(2'd0, 8'hFF, "R6");
        check("R6", "write all ones", int'(csr_rdata), 8'hDF);
        sw(2'd2, 8'h0F, "R5");
        check("R5", "clear mask", int'(csr_rdata), 8'hD0);
        sw(2'd3, 8'h00, "R5");
        check("R5", "no reset from access", int'(sys_rst), 0);
        sw(2'd0, 8'h00, "R5");

        // R7: glitch of three low samples ignored
        mclr_n = 0; idle(FILT - 1, "R7"); mclr_n = 1;
        idle(3, "R7");
        check("R7", "glitch ignored", int'(sys_rst), 0);
        check("R7", "no pin flag", int'(csr_rdata), 8'h00);
        // R7: long low accepted
        mclr_n = 0; idle(FILT + 3, "R7"); mclr_n = 1;
        idle(1, "R7");
        check("R7", "pin flag set", int'(csr_rdata), 8'h80);
        idle(HOLD + 2, "R8");

        // R4: simultaneous sources
        wdt_req = 1; trap_req = 1; swr_req = 1;
        tick("R4");
        quiet();
        check("R4", "simultaneous flags", int'(csr_rdata), 8'hD8);
        // R8: hold measured from last active cycle
        bor_req = 1; idle(3, "R8"); bor_req = 0;
        idle(HOLD - 1, "R8");
        check("R8", "still held", int'(sys_rst), 1);
        idle(1, "R8");
        check("R8", "released", int'(sys_rst), 0);

        // R9: clear and request on same bit
        csr_we = 1; csr_op = 2'd2; csr_wdata = 8'hFF; iop_req = 1;
        tick("R9");
        quiet();
        check("R9", "hardware wins", int'(csr_rdata), 8'h04);
        idle(HOLD + 2, "R9");

        // R3: power-on clears accumulated flags
        wdt_req = 1; tick("R3"); wdt_req = 0;
        por_req = 1; swr_req = 1; tick("R3"); quiet();
        check("R3", "power-on wipe", int'(csr_rdata), 8'h01);
        idle(HOLD + 2, "R8");

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule